// File: doc/BRIEF.md
# Prefix Parity Scanner

This block is purely combinational. It takes a vector of `WIDTH` bits and returns a vector of the same width. Each output bit carries the parity of its own input bit together with every input bit below it. A reader therefore gets all running parities of the input at once. Typical uses are marking odd/even positions of set bits and decoding a vector whose bits each toggle the sense of all bits above them.

The network has `log2(WIDTH)` levels. At level `k`, every bit whose index is at least `2^k` XORs its current value with the value held `2^k` positions below it. Lower bits pass through unchanged. Partial results are shared between outputs, so the gate count is `O(WIDTH log2 WIDTH)` and the depth is logarithmic. `WIDTH` must be a power of two, and the levels are generated from it.

Top module: `xor_scan`

## Requirements
- R1: For every input, `scan_o[i]` equals the XOR of `vec_i[0]` through `vec_i[i]`, for every i in 0..WIDTH-1.
- R2: `scan_o[0]` always equals `vec_i[0]`.
- R3: `scan_o[WIDTH-1]` always equals the XOR reduction of all of `vec_i`.
- R4: Flipping a single input bit j flips exactly the output bits j..WIDTH-1 and leaves output bits 0..j-1 unchanged.
- R5: An all-zero input gives an all-zero output. An all-ones input sets exactly the output bits with even index (0, 2, 4, ...).
- R6: For every i from 1 to WIDTH-1, `scan_o[i] ^ scan_o[i-1]` equals `vec_i[i]`.
- R7: The network has exactly `$clog2(WIDTH)` XOR levels. Level k pairs bit i with bit i-2^k for every i ≥ 2^k, so the logic depth is log2 WIDTH.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| vec_i | input | WIDTH | Input vector, bit 0 is the lowest position |
| scan_o | output | WIDTH | Running parity of each prefix of `vec_i` |

## Verification
The bench builds two copies of the block, one with `WIDTH` = 8 and one with `WIDTH` = 16. Both are driven from one 16-bit sweep covering all 65536 values, so the 16-bit copy sees every input it can receive and the 8-bit copy sees each of its 256 inputs many times. Both widths are therefore checked exhaustively for full prefix parity, for the end bits and for the step relation between adjacent outputs. Single-bit flips from several base patterns show that each level of the 16-bit network (spans 1, 2, 4 and 8) carries toggles upward, and only upward.

// File: rtl/xor_scan_pkg.sv
package xor_scan_pkg;
  function automatic bit is_pow2(input int unsigned w);
    return (w != 0) && ((w & (w - 1)) == 0);
  endfunction

  function automatic int unsigned scan_levels(input int unsigned w);
    return (w <= 1) ? 1 : $clog2(w);
  endfunction
endpackage

// File: rtl/xor_scan_stage.sv
// One level of the prefix network: bit i takes din[i] ^ din[i-SPAN]
module xor_scan_stage #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned SPAN  = 1
) (
  input  logic [WIDTH-1:0] din_i,
  output logic [WIDTH-1:0] dout_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    if (i < SPAN) begin : g_pass
      assign dout_o[i] = din_i[i];
    end else begin : g_mix
      assign dout_o[i] = din_i[i] ^ din_i[i-SPAN];
    end
  end

  // R7: bits below SPAN are untouched at this level
  always_comb begin
    if (!$isunknown(din_i)) begin
      // R7
      low_pass_chk: assert (dout_o[0] == din_i[0]);
    end
  end
endmodule

// File: rtl/xor_scan.sv
module xor_scan
  import xor_scan_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] vec_i,
  output logic [WIDTH-1:0] scan_o
);
  localparam int unsigned LEVELS = scan_levels(WIDTH);

  logic [WIDTH-1:0] lvl [LEVELS+1];

  assign lvl[0] = vec_i;

  for (genvar k = 0; k < LEVELS; k++) begin : g_lvl
    xor_scan_stage #(
      .WIDTH (WIDTH),
      .SPAN  (1 << k)
    ) u_stage (
      .din_i  (lvl[k]),
      .dout_o (lvl[k+1])
    );
  end

  assign scan_o = lvl[LEVELS];

  always_comb begin
    if (!$isunknown(vec_i)) begin
      // R2
      first_bit_chk: assert (scan_o[0] == vec_i[0]);
      // R3
      total_par_chk: assert (scan_o[WIDTH-1] == ^vec_i);
      // R6
      step_diff_chk: assert ((scan_o ^ (scan_o << 1)) == vec_i);
      // R5
      zero_in_chk: assert ((vec_i != '0) || (scan_o == '0));
    end
  end

  initial begin
    // R7
    width_pow2_chk: assert (is_pow2(WIDTH));
  end
endmodule

// File: tb/xor_scan_tb.sv
`timescale 1ns/1ps
module xor_scan_tb;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [7:0]  v8,  s8;
  logic [15:0] v16, s16;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  xor_scan #(.WIDTH(8)) u_dut (.vec_i(v8), .scan_o(s8));
  xor_scan #(.WIDTH(16)) u_dut_w16 (.vec_i(v16), .scan_o(s16));

  function automatic logic [15:0] ref_scan(input logic [15:0] v, input int w);
    logic [15:0] r = '0;
    logic acc = 1'b0;
    for (int i = 0; i < w; i++) begin
      acc = acc ^ v[i];
      r[i] = acc;
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [15:0] v);
    @(posedge clk);
    v16 = v;
    v8  = v[7:0];
    @(negedge clk);
  endtask

  initial begin
    v8 = '0; v16 = '0;
    // R5: zero and all-ones
    apply(16'h0000);
    chk(s8 == 8'h00, "R5 zero w8", {8'h0, s8}, 16'h0);
    chk(s16 == 16'h0000, "R5 zero w16", s16, 16'h0);
    apply(16'hFFFF);
    chk(s8 == 8'h55, "R5 ones w8", {8'h0, s8}, 16'h0055);
    chk(s16 == 16'h5555, "R5 ones w16", s16, 16'h5555);

    // R1 R2 R3 R6: exhaustive sweep
    for (int x = 0; x < 65536; x++) begin
      logic [15:0] e16, e8;
      apply(x[15:0]);
      e16 = ref_scan(x[15:0], 16);
      e8  = ref_scan({8'h0, x[7:0]}, 8);
      chk(s16 == e16, "R1 w16", s16, e16);
      chk(s8 == e8[7:0], "R1 w8", {8'h0, s8}, e8);
      chk(s16[0] == x[0], "R2 w16", {15'h0, s16[0]}, {15'h0, x[0]});
      chk(s16[15] == ^x[15:0], "R3 w16", {15'h0, s16[15]}, {15'h0, ^x[15:0]});
      chk(s8[7] == ^x[7:0], "R3 w8", {15'h0, s8[7]}, {15'h0, ^x[7:0]});
      chk((s16 ^ (s16 << 1)) == x[15:0], "R6 w16", s16 ^ (s16 << 1), x[15:0]);
    end

    // R4 R7: single-bit flips from several bases
    for (int b = 0; b < 4; b++) begin
      logic [15:0] base, s0, m;
      base = (b == 0) ? 16'h0000 : (b == 1) ? 16'hFFFF : (b == 2) ? 16'hA5C3 : 16'h1E69;
      apply(base);
      s0 = s16;
      for (int j = 0; j < 16; j++) begin
        m = 16'hFFFF << j;
        apply(base ^ (16'h1 << j));
        chk((s16 ^ s0) == m, "R4 R7 flip w16", s16 ^ s0, m);
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog act=%0d exp=0", 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule